// File: doc/BRIEF.md
# Fault-Class Word Redirection Controller

This block sits between a requester and a word-addressed memory whose 64-bit words travel as 72-bit SECDED codewords. The encoder and decoder sit outside; the block only sees the decoder's uncorrectable-error flag and the corrected read data. For each primary word it holds a two-bit fault class and the index of a spare word in a reserved replica region. Both are loaded through a configuration port while a test-mode input is high. Every request is then routed by the word's class.

A clean word is served from its primary location alone, and SECDED covers any soft error on it. A word with one known hard bit stays in service, but the block mirrors every write into its replica. On a read, the block falls back to the replica only when the primary read comes back uncorrectable. A word with several faulty bits is retired, and every access to it goes to the replica. All memory traffic uses one request port that is held until the memory's done pulse. While test mode is high, no new request is taken.

Top module: `fmap_redirect`

## Requirements
- R1: After reset, every table entry is class clean, `rsp_valid` and `mem_valid` are low, and `req_ready` is high while `test_mode` is low.
- R2: A table entry is written from `cfg_class`/`cfg_rep` at index `cfg_idx` only on a clock edge where both `cfg_we` and `test_mode` are high. `cfg_we` has no effect while `test_mode` is low.
- R3: While `test_mode` is high, `req_ready` is low and no new memory access starts.
- R4: Class 2'b00 (clean): a read or write makes exactly one memory access, at primary address {1'b0, req_addr}. A read returns that data.
- R5: Class 2'b01 (single-bit): a write makes two memory writes with the same data. The first goes to the primary address. The second goes to the replica address, which is {1'b1, replica index zero-extended to AW bits}. The response comes only after the second write completes.
- R6: Class 2'b01 read: the primary is read first. If `mem_ue` is low at its done pulse, the primary data is returned. If `mem_ue` is high, the replica is read and its data is returned.
- R7: Classes 2'b10 and 2'b11 (retired): every read or write makes exactly one access, to the replica address only.
- R8: `rsp_err` is high on a read response exactly when the access whose data is returned reported `mem_ue`. On a write response it is low.
- R9: `mem_addr`, `mem_write` and `mem_wdata` stay stable while `mem_valid` is high and `mem_done` is low. `rsp_valid` is a one-cycle pulse in the cycle after the final `mem_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | Configuration phase; stalls requests |
| cfg_we | input | 1 | Table write strobe (needs test_mode) |
| cfg_idx | input | AW | Word index to configure |
| cfg_class | input | 2 | Fault class to store |
| cfg_rep | input | RW | Replica index to store |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Primary word index |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | DW | Read data (zero on writes) |
| rsp_err | output | 1 | Uncorrectable data returned |
| mem_valid | output | 1 | Memory access request, held until done |
| mem_write | output | 1 | Memory access is a write |
| mem_addr | output | AW+1 | MSB selects replica region |
| mem_wdata | output | DW | Memory write data |
| mem_done | input | 1 | Access completion pulse |
| mem_rdata | input | DW | Decoded read data |
| mem_ue | input | 1 | Decoder uncorrectable-error flag |

## Verification
A wrong class or replica index in the table shows up on the very first access to that word. The memory sees the wrong number of accesses or the wrong region, and later reads return stale data from the location that should have been written. A sequencer that skips or repeats a step shows up within one transaction. Either a mirrored write lands only once, or an uncorrectable primary read is returned instead of the replica data, with the wrong `rsp_err`. Random traffic over all classes with random error flags, compared against the bench's own shadow memory, exposes each of these on the response of the faulty transaction.

// File: rtl/fmr_pkg.sv
package fmr_pkg;

  localparam logic [1:0] FC_CLEAN  = 2'b00;
  localparam logic [1:0] FC_SINGLE = 2'b01;
  localparam logic [1:0] FC_MULTI  = 2'b10;
  localparam logic [1:0] FC_RSVD   = 2'b11;

  typedef enum logic [1:0] {
    S_IDLE = 2'b00,
    S_PRI  = 2'b01,
    S_REP  = 2'b10
  } seq_e;

  // retired words (multi-bit or reserved code) live only in their replica
  function automatic logic is_retired(input logic [1:0] c);
    return c[1];
  endfunction

  // single-bit words are served from primary and mirrored to replica
  function automatic logic is_mirrored(input logic [1:0] c);
    return c == FC_SINGLE;
  endfunction

endpackage

// File: rtl/fmr_map.sv
module fmr_map #(
  parameter int AW = 6,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          test_mode,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_idx,
  input  logic [1:0]    cfg_class,
  input  logic [RW-1:0] cfg_rep,
  input  logic [AW-1:0] rd_idx,
  output logic [1:0]    rd_class,
  output logic [RW-1:0] rd_rep
);
  localparam int NW = 1 << AW;

  logic          wr_fire;
  logic [1:0]    cls_w [NW];
  logic [RW-1:0] rep_w [NW];

  assign wr_fire = cfg_we && test_mode;

  for (genvar i = 0; i < NW; i++) begin : g_ent
    logic [1:0]    c_q;
    logic [RW-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_q <= fmr_pkg::FC_CLEAN;
        r_q <= '0;
      end else if (wr_fire && cfg_idx == AW'(i)) begin
        c_q <= cfg_class;
        r_q <= cfg_rep;
      end
    end
    assign cls_w[i] = c_q;
    assign rep_w[i] = r_q;
  end

  assign rd_class = cls_w[rd_idx];
  assign rd_rep   = rep_w[rd_idx];

  // R2: an entry read back at a fixed index only changes after a gated write
  assert_cfg_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_idx) == rd_idx) && !$past(test_mode) |-> $stable(rd_class) && $stable(rd_rep));

endmodule

// File: rtl/fmr_seq.sv
module fmr_seq
  import fmr_pkg::*;
#(
  parameter int AW = 6,
  parameter int RW = 4,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          test_mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    lk_class,
  input  logic [RW-1:0] lk_rep,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW:0]   mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_done,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ue
);

  function automatic logic [AW:0] pri_addr(input logic [AW-1:0] a);
    return {1'b0, a};
  endfunction

  function automatic logic [AW:0] rep_addr(input logic [RW-1:0] r);
    logic [AW:0] t;
    t = '0;
    t[RW-1:0] = r;
    t[AW] = 1'b1;
    return t;
  endfunction

  seq_e          state;
  logic          op_write;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wdata;
  logic [1:0]    op_class;
  logic [RW-1:0] op_rep;

  // named internal events
  logic accept;
  logic go_rep;
  logic finish;

  assign req_ready = (state == S_IDLE) && !test_mode;
  assign accept    = req_valid && req_ready;
  assign go_rep    = (state == S_PRI) && mem_done && is_mirrored(op_class)
                     && (op_write || mem_ue);
  assign finish    = mem_done && ((state == S_PRI && !go_rep) || state == S_REP);

  assign mem_valid = (state != S_IDLE);
  assign mem_write = op_write;
  assign mem_wdata = op_wdata;
  assign mem_addr  = (state == S_REP) ? rep_addr(op_rep) : pri_addr(op_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      op_write  <= 1'b0;
      op_addr   <= '0;
      op_wdata  <= '0;
      op_class  <= FC_CLEAN;
      op_rep    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          op_write <= req_write;
          op_addr  <= req_addr;
          op_wdata <= req_wdata;
          op_class <= lk_class;
          op_rep   <= lk_rep;
          state    <= is_retired(lk_class) ? S_REP : S_PRI;
        end
        S_PRI: if (go_rep) state <= S_REP;
               else if (finish) state <= S_IDLE;
        S_REP: if (finish) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (finish) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= op_write ? '0 : mem_rdata;
        rsp_err   <= !op_write && mem_ue;
      end
    end
  end

  assert_no_start_in_test_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> !$past(test_mode));

  assert_clean_primary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && op_class == FC_CLEAN |-> !mem_addr[AW]);

  assert_mirror_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_done && mem_write && !mem_addr[AW] && op_class == FC_SINGLE
    |=> mem_valid && mem_addr[AW] && !rsp_valid);

  assert_ue_retry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_done && !mem_write && !mem_addr[AW] && op_class == FC_SINGLE && mem_ue
    |=> mem_valid && mem_addr[AW] && !rsp_valid);

  assert_retired_replica_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && op_class[1] |-> mem_addr[AW]);

  assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_done |=> mem_valid && $stable(mem_addr)
    && $stable(mem_write) && $stable(mem_wdata));

  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/fmap_redirect.sv
module fmap_redirect #(
  parameter int AW = 6,
  parameter int RW = 4,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          test_mode,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_idx,
  input  logic [1:0]    cfg_class,
  input  logic [RW-1:0] cfg_rep,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW:0]   mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_done,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ue
);

  logic [1:0]    lk_class;
  logic [RW-1:0] lk_rep;

  fmr_map #(.AW(AW), .RW(RW)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_class (cfg_class),
    .cfg_rep   (cfg_rep),
    .rd_idx    (req_addr),
    .rd_class  (lk_class),
    .rd_rep    (lk_rep)
  );

  fmr_seq #(.AW(AW), .RW(RW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .lk_class  (lk_class),
    .lk_rep    (lk_rep),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .mem_valid (mem_valid),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_done  (mem_done),
    .mem_rdata (mem_rdata),
    .mem_ue    (mem_ue)
  );

endmodule

// File: tb/tb_fmap_redirect.sv
`timescale 1ns/1ps
module tb_fmap_redirect;
  localparam int AW = 6;
  localparam int RW = 4;
  localparam int DW = 64;
  localparam int NW = 1 << AW;
  localparam int NR = 1 << RW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_mode = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_idx = '0;
  logic [1:0] cfg_class = '0;
  logic [RW-1:0] cfg_rep = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic rsp_err;
  logic mem_valid, mem_write;
  logic [AW:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic mem_done = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic mem_ue = 1'b0;

  always #2.5 clk = ~clk;

  fmap_redirect #(.AW(AW), .RW(RW), .DW(DW)) dut (.*);

  int total = 0;
  int bad = 0;

  // bench tables and memory model state
  logic [1:0]    tcls [NW];
  logic [RW-1:0] trep [NW];
  logic [DW-1:0] sp [NW];
  logic [DW-1:0] sr [NR];
  logic [DW-1:0] mp [NW];
  logic [DW-1:0] mr [NR];
  logic ue_p [NW];
  logic ue_r [NR];
  int lw [8];
  int la [8];
  int ln = 0;
  int wcnt = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // memory model, driven on the falling edge
  always @(negedge clk) begin
    if (mem_done) begin
      mem_done = 1'b0;
      mem_ue = 1'b0;
    end else if (mem_valid) begin
      if (wcnt == 0) begin
        if (ln < 8) begin lw[ln] = int'(mem_write); la[ln] = int'(mem_addr); end
        ln++;
        if (mem_write) begin
          if (mem_addr[AW]) mr[mem_addr[RW-1:0]] = mem_wdata;
          else mp[mem_addr[AW-1:0]] = mem_wdata;
          mem_ue = 1'b0;
        end else begin
          mem_rdata = mem_addr[AW] ? mr[mem_addr[RW-1:0]] : mp[mem_addr[AW-1:0]];
          mem_ue = mem_addr[AW] ? ue_r[mem_addr[RW-1:0]] : ue_p[mem_addr[AW-1:0]];
        end
        mem_done = 1'b1;
        wcnt = int'($urandom % 3);
      end else wcnt--;
    end
  end

  function automatic string tag_of(input logic [1:0] c, input bit w);
    if (c == 2'b00) return "R4";
    if (c == 2'b01) return w ? "R5" : "R6";
    return "R7";
  endfunction

  task automatic run_op(input bit w, input int a, input logic [DW-1:0] d, input string tg);
    int en;
    int ea [2];
    int r;
    logic [DW-1:0] ed;
    bit ee;
    int to;
    logic [1:0] c;
    c = tcls[a];
    r = int'(trep[a]);
    ed = '0;
    ee = 1'b0;
    if (c == 2'b00) begin
      en = 1; ea[0] = a;
      if (w) sp[a] = d; else begin ed = sp[a]; ee = ue_p[a]; end
    end else if (c == 2'b01) begin
      ea[0] = a; ea[1] = NW + r;
      if (w) begin en = 2; sp[a] = d; sr[r] = d; end
      else if (ue_p[a]) begin en = 2; ed = sr[r]; ee = ue_r[r]; end
      else begin en = 1; ed = sp[a]; end
    end else begin
      en = 1; ea[0] = NW + r;
      if (w) sr[r] = d; else begin ed = sr[r]; ee = ue_r[r]; end
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    ln = 0;
    req_valid = 1'b1; req_write = w; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    to = 0;
    while (!rsp_valid && to < 60) begin @(negedge clk); to++; end
    chk(rsp_valid, tg, "response arrives", DW'(rsp_valid), 1);
    chk(ln == en, tg, "access count", DW'(ln), DW'(en));
    for (int k = 0; k < en && k < ln; k++) begin
      chk(la[k] == ea[k], tg, "access address", DW'(la[k]), DW'(ea[k]));
      chk(lw[k] == int'(w), tg, "access direction", DW'(lw[k]), DW'(w));
    end
    chk(rsp_rdata == ed, tg, "read data", rsp_rdata, ed);
    chk(rsp_err == ee, "R8", "error bit", DW'(rsp_err), DW'(ee));
    @(negedge clk);
    chk(!rsp_valid, "R9", "response is one cycle", DW'(rsp_valid), 0);
  endtask

  task automatic cfg_write(input int a, input logic [1:0] c, input int r);
    cfg_we = 1'b1; cfg_idx = AW'(a); cfg_class = c; cfg_rep = RW'(r);
    @(negedge clk);
    cfg_we = 1'b0;
    if (test_mode) begin tcls[a] = c; trep[a] = RW'(r); end
  endtask

  initial begin
    #(5.0 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NW; i++) begin
      tcls[i] = 2'b00; trep[i] = '0;
      sp[i] = {$urandom, $urandom}; mp[i] = sp[i]; ue_p[i] = 1'b0;
    end
    for (int i = 0; i < NR; i++) begin
      sr[i] = {$urandom, $urandom}; mr[i] = sr[i]; ue_r[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready, "R1", "ready after reset", DW'(req_ready), 1);
    chk(!rsp_valid, "R1", "no response after reset", DW'(rsp_valid), 0);
    chk(!mem_valid, "R1", "no access after reset", DW'(mem_valid), 0);
    run_op(1'b0, 5, '0, "R1");
    run_op(1'b1, 40, 64'h1111_2222_3333_4444, "R1");

    // R2: cfg write with test mode low must not retire word 7
    cfg_write(7, 2'b10, 3);
    run_op(1'b0, 7, '0, "R2");

    // R3: stall under test mode
    test_mode = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 6'd9;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!req_ready, "R3", "ready low in test mode", DW'(req_ready), 0);
      chk(!mem_valid, "R3", "no access in test mode", DW'(mem_valid), 0);
    end
    for (int i = 0; i < NW; i++) begin
      int p;
      logic [1:0] c;
      p = int'($urandom % 8);
      c = (p < 3) ? 2'b00 : (p < 6) ? 2'b01 : (p == 6) ? 2'b10 : 2'b11;
      cfg_write(i, c, int'($urandom % NR));
    end
    cfg_write(3, 2'b11, 2);
    cfg_write(4, 2'b01, 5);
    cfg_write(6, 2'b10, 9);
    cfg_write(7, 2'b00, 0);
    chk(!mem_valid, "R3", "no access during config", DW'(mem_valid), 0);
    req_valid = 1'b0;
    test_mode = 1'b0;

    // directed corners
    run_op(1'b1, 4, 64'hDEAD_BEEF_0000_0004, "R5");
    ue_p[4] = 1'b1; ue_r[5] = 1'b0;
    run_op(1'b0, 4, '0, "R6");
    ue_r[5] = 1'b1;
    run_op(1'b0, 4, '0, "R8");
    ue_p[4] = 1'b0;
    run_op(1'b0, 4, '0, "R6");
    run_op(1'b1, 3, 64'hA5A5_0000_0000_0003, "R7");
    run_op(1'b0, 3, '0, "R7");
    run_op(1'b0, 6, '0, "R7");
    ue_p[7] = 1'b1;
    run_op(1'b0, 7, '0, "R8");
    ue_p[7] = 1'b0;

    // random traffic
    for (int n = 0; n < 400; n++) begin
      int a;
      bit w;
      a = int'($urandom % NW);
      w = bit'($urandom % 2);
      for (int i = 0; i < NW; i++) ue_p[i] = (($urandom % 4) == 0);
      for (int i = 0; i < NR; i++) ue_r[i] = (($urandom % 5) == 0);
      run_op(w, a, {$urandom, $urandom}, tag_of(tcls[a], w));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule